// File: doc/BRIEF.md
# Program and Data Address Pointer Unit

This block holds the address registers of a small 8-bit processor: a program counter that drives the fetch address, a single return slot that holds one saved program address, and a pair of data counters. The primary data counter drives the data address. The alternate data counter is a second one that can be swapped in. Instruction decode sits outside the block. It presents one operation code per cycle, together with the byte-wide values that code may need: a scratchpad register pair, two immediate operand bytes and the accumulator.

Two event inputs are handled ahead of any operation. A processor reset event zeroes the program counter and keeps its old value in the return slot. An interrupt event moves the program counter into the return slot and loads the vector supplied with the event. A separate synchronous reset clears every register, so the unit starts from a known state. All outputs come straight from registers and change one clock after the request.

Top module: `ptr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all four registers (program counter, return slot, data counter, alternate data counter) become 0000h at that edge. `rst` overrides every other input.
- R2: When `vec_rst` is high, the program counter becomes 0000h and the return slot takes the old program counter. Both data counters are unchanged, `op` has no effect, and `vec_rst` wins over `irq_take`.
- R3: When `irq_take` is high and `vec_rst` is low, the return slot takes the old program counter and the program counter takes `irq_vec`. Both data counters are unchanged and `op` has no effect.
- R4: Operation code 1 adds one to the program counter. FFFFh wraps to 0000h.
- R5: Code 2 loads the program counter from the pair, with the upper byte from `pair_hi` and the lower byte from `pair_lo`. Code 3 does the same load and also saves the old program counter in the return slot.
- R6: Code 6 copies the return slot into the program counter and leaves the return slot unchanged.
- R7: Code 5 loads the program counter from {`imm_hi`,`imm_lo`}. Code 4 does the same and also saves the old program counter in the return slot.
- R8: Code 7 loads the return slot from {`pair_hi`,`pair_lo`} without touching the program counter.
- R9: Code 8 loads the data counter from {`pair_hi`,`pair_lo`} and code 9 loads it from {`imm_hi`,`imm_lo`}. The alternate counter does not change.
- R10: Code 10 swaps the data counter and the alternate data counter in one cycle.
- R11: Code 11 (a memory access through the data counter) adds one to the data counter. FFFFh wraps to 0000h.
- R12: Code 12 adds `acc` to the data counter as a two's-complement value sign-extended to 16 bits, modulo 2^16.
- R13: Code 0 and the unused codes 13 to 15 leave all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| vec_rst | input | 1 | Processor reset event: program counter to zero, old value saved |
| irq_take | input | 1 | Interrupt event: program counter saved, vector loaded |
| irq_vec | input | 16 | Interrupt vector address |
| op | input | 4 | Pointer operation code |
| acc | input | 8 | Accumulator value for the offset add |
| pair_hi | input | 8 | Upper byte from the selected scratchpad pair |
| pair_lo | input | 8 | Lower byte from the selected scratchpad pair |
| imm_hi | input | 8 | Upper immediate operand byte |
| imm_lo | input | 8 | Lower immediate operand byte |
| fetch_addr | output | 16 | Program counter |
| ret_addr | output | 16 | Return slot |
| data_addr | output | 16 | Primary data counter |
| alt_addr | output | 16 | Alternate data counter |

## Verification
The bench runs the offset add over every accumulator value from three base addresses, including bases near 0000h and FFFFh. A unit that zero-extends the accumulator, or that drops the carry into the upper byte, shows a wrong data address there. It forces both counters across FFFFh, where a wrong wrap would appear. It raises the reset event and the interrupt together with an active operation, which exposes a unit that lets an instruction through or takes the wrong priority. A long pseudo-random mix of every code, including the unused ones, catches swaps and saves that write the wrong slot or corrupt the counter that should hold.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 4'd0,
    OP_PC_INC     = 4'd1,
    OP_PC_LD_PAIR = 4'd2,
    OP_CALL_PAIR  = 4'd3,
    OP_CALL_IMM   = 4'd4,
    OP_JMP_IMM    = 4'd5,
    OP_RETURN     = 4'd6,
    OP_RET_LD     = 4'd7,
    OP_DC_LD_PAIR = 4'd8,
    OP_DC_LD_IMM  = 4'd9,
    OP_DC_XCHG    = 4'd10,
    OP_DC_STEP    = 4'd11,
    OP_DC_ADD_ACC = 4'd12
  } ptr_op_e;
endpackage

// File: rtl/offset_adder.sv
module offset_adder #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] sum
);
  generate
    if (AW > OW) begin : g_ext
      localparam int EXT = AW - OW;
      assign sum = base + {{EXT{off[OW-1]}}, off};
    end else begin : g_flat
      assign sum = base + off[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/pc_path.sv
module pc_path
  import ptr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vrst,
  input  logic            irq,
  input  logic [AW-1:0]   irq_vec,
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   pair,
  input  logic [AW-1:0]   imm,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   ret_q
);
  logic [AW-1:0] pc_next_seq;

  offset_adder #(.AW(AW), .OW(2)) u_inc (
    .base(pc_q),
    .off (2'b01),
    .sum (pc_next_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ret_q <= '0;
    end else if (vrst) begin
      ret_q <= pc_q;
      pc_q  <= '0;
    end else if (irq) begin
      ret_q <= pc_q;
      pc_q  <= irq_vec;
    end else begin
      case (op)
        OP_PC_INC:     pc_q <= pc_next_seq;
        OP_PC_LD_PAIR: pc_q <= pair;
        OP_CALL_PAIR: begin
          ret_q <= pc_q;
          pc_q  <= pair;
        end
        OP_CALL_IMM: begin
          ret_q <= pc_q;
          pc_q  <= imm;
        end
        OP_JMP_IMM:    pc_q  <= imm;
        OP_RETURN:     pc_q  <= ret_q;
        OP_RET_LD:     ret_q <= pair;
        default: ;
      endcase
    end
  end

  a_r1_clear_pc: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && ret_q == '0));

  a_r2_vec_reset: assert property (@(posedge clk) disable iff (rst)
    vrst |=> (pc_q == '0 && ret_q == $past(pc_q)));

  a_r3_irq_vector: assert property (@(posedge clk) disable iff (rst)
    (irq && !vrst) |=> (pc_q == $past(irq_vec) && ret_q == $past(pc_q)));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!vrst && !irq && op == OP_PC_INC) |=> (pc_q == $past(pc_q) + AW'(1)));

  a_r6_return: assert property (@(posedge clk) disable iff (rst)
    (!vrst && !irq && op == OP_RETURN) |=> (pc_q == $past(ret_q) && $stable(ret_q)));

  a_r8_ret_load: assert property (@(posedge clk) disable iff (rst)
    (!vrst && !irq && op == OP_RET_LD) |=> ($stable(pc_q) && ret_q == $past(pair)));
endmodule

// File: rtl/dc_path.sv
module dc_path
  import ptr_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   pair,
  input  logic [AW-1:0]   imm,
  input  logic [BW-1:0]   acc,
  output logic [AW-1:0]   dc_q,
  output logic [AW-1:0]   alt_q
);
  localparam logic [BW-1:0] ONE = BW'(1);

  logic [BW-1:0] off;
  logic [AW-1:0] dc_sum;

  assign off = (op == OP_DC_STEP) ? ONE : acc;

  offset_adder #(.AW(AW), .OW(BW)) u_add (
    .base(dc_q),
    .off (off),
    .sum (dc_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dc_q  <= '0;
      alt_q <= '0;
    end else if (!hold) begin
      case (op)
        OP_DC_LD_PAIR: dc_q <= pair;
        OP_DC_LD_IMM:  dc_q <= imm;
        OP_DC_XCHG: begin
          dc_q  <= alt_q;
          alt_q <= dc_q;
        end
        OP_DC_STEP,
        OP_DC_ADD_ACC: dc_q <= dc_sum;
        default: ;
      endcase
    end
  end

  a_r1_clear_dc: assert property (@(posedge clk)
    rst |=> (dc_q == '0 && alt_q == '0));

  a_r3_dc_hold: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(dc_q) && $stable(alt_q)));

  a_r10_swap: assert property (@(posedge clk) disable iff (rst)
    (!hold && op == OP_DC_XCHG) |=> (dc_q == $past(alt_q) && alt_q == $past(dc_q)));

  a_r11_step: assert property (@(posedge clk) disable iff (rst)
    (!hold && op == OP_DC_STEP) |=> (dc_q == $past(dc_q) + AW'(1) && $stable(alt_q)));

  a_r12_signed_add: assert property (@(posedge clk) disable iff (rst)
    (!hold && op == OP_DC_ADD_ACC) |=>
      (dc_q == $past(dc_q) + {{(AW-BW){$past(acc[BW-1])}}, $past(acc)}));

  a_r13_idle: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP || op > OP_DC_ADD_ACC) |=> ($stable(dc_q) && $stable(alt_q)));
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_rst,
  input  logic              irq_take,
  input  logic [2*BW-1:0]   irq_vec,
  input  logic [OP_W-1:0]   op,
  input  logic [BW-1:0]     acc,
  input  logic [BW-1:0]     pair_hi,
  input  logic [BW-1:0]     pair_lo,
  input  logic [BW-1:0]     imm_hi,
  input  logic [BW-1:0]     imm_lo,
  output logic [2*BW-1:0]   fetch_addr,
  output logic [2*BW-1:0]   ret_addr,
  output logic [2*BW-1:0]   data_addr,
  output logic [2*BW-1:0]   alt_addr
);
  localparam int AW = 2 * BW;

  logic [AW-1:0] pair_w;
  logic [AW-1:0] imm_w;
  logic          dc_hold;

  assign pair_w  = {pair_hi, pair_lo};
  assign imm_w   = {imm_hi, imm_lo};
  assign dc_hold = vec_rst | irq_take;

  pc_path #(.AW(AW)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .vrst   (vec_rst),
    .irq    (irq_take),
    .irq_vec(irq_vec),
    .op     (op),
    .pair   (pair_w),
    .imm    (imm_w),
    .pc_q   (fetch_addr),
    .ret_q  (ret_addr)
  );

  dc_path #(.AW(AW), .BW(BW)) u_dc (
    .clk  (clk),
    .rst  (rst),
    .hold (dc_hold),
    .op   (op),
    .pair (pair_w),
    .imm  (imm_w),
    .acc  (acc),
    .dc_q (data_addr),
    .alt_q(alt_addr)
  );

  a_r2_vec_over_irq: assert property (@(posedge clk) disable iff (rst)
    (vec_rst && irq_take) |=> (fetch_addr == '0));
endmodule

// File: tb/sim_ptr_unit.sv
module sim_ptr_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vec_rst = 1'b0;
  logic        irq_take = 1'b0;
  logic [15:0] irq_vec = '0;
  logic [3:0]  op = '0;
  logic [7:0]  acc = '0;
  logic [7:0]  pair_hi = '0, pair_lo = '0, imm_hi = '0, imm_lo = '0;
  logic [15:0] fetch_addr, ret_addr, data_addr, alt_addr;

  logic [15:0] m_pc = '0, m_ret = '0, m_dc = '0, m_alt = '0;
  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #(CLK_P/2) clk = ~clk;

  ptr_unit u0 (
    .clk(clk), .rst(rst), .vec_rst(vec_rst), .irq_take(irq_take),
    .irq_vec(irq_vec), .op(op), .acc(acc), .pair_hi(pair_hi),
    .pair_lo(pair_lo), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .fetch_addr(fetch_addr), .ret_addr(ret_addr),
    .data_addr(data_addr), .alt_addr(alt_addr)
  );

  task automatic compare(input string req);
    checks++;
    if (fetch_addr !== m_pc || ret_addr !== m_ret ||
        data_addr !== m_dc || alt_addr !== m_alt) begin
      errors++;
      $display("FAIL %s got pc=%h ret=%h dc=%h alt=%h exp pc=%h ret=%h dc=%h alt=%h",
               req, fetch_addr, ret_addr, data_addr, alt_addr,
               m_pc, m_ret, m_dc, m_alt);
    end
  endtask

  task automatic do_clear(input string req);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    m_pc = '0; m_ret = '0; m_dc = '0; m_alt = '0;
    compare(req);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic [3:0] o, input logic vr, input logic irq,
                      input logic [15:0] vec, input logic [7:0] a,
                      input logic [15:0] pr, input logic [15:0] im,
                      input string req);
    logic [15:0] e_pc, e_ret, e_dc, e_alt;
    @(negedge clk);
    op = o; vec_rst = vr; irq_take = irq; irq_vec = vec; acc = a;
    {pair_hi, pair_lo} = pr; {imm_hi, imm_lo} = im;
    e_pc = m_pc; e_ret = m_ret; e_dc = m_dc; e_alt = m_alt;
    if (vr) begin
      e_ret = m_pc; e_pc = 16'h0000;
    end else if (irq) begin
      e_ret = m_pc; e_pc = vec;
    end else begin
      case (o)
        4'd1:  e_pc = m_pc + 16'd1;
        4'd2:  e_pc = pr;
        4'd3:  begin e_ret = m_pc; e_pc = pr; end
        4'd4:  begin e_ret = m_pc; e_pc = im; end
        4'd5:  e_pc = im;
        4'd6:  e_pc = m_ret;
        4'd7:  e_ret = pr;
        4'd8:  e_dc = pr;
        4'd9:  e_dc = im;
        4'd10: begin e_dc = m_alt; e_alt = m_dc; end
        4'd11: e_dc = m_dc + 16'd1;
        4'd12: e_dc = m_dc + {{8{a[7]}}, a};
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    m_pc = e_pc; m_ret = e_ret; m_dc = e_dc; m_alt = e_alt;
    compare(req);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R9 loads
    step(4'd9, 0, 0, 16'h0, 8'h0, 16'h0, 16'h1234, "R9 dc imm");
    step(4'd8, 0, 0, 16'h0, 8'h0, 16'hBEEF, 16'h0, "R9 dc pair");
    // R10 swap twice
    step(4'd10, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R10 swap");
    step(4'd9, 0, 0, 16'h0, 8'h0, 16'h0, 16'h5A5A, "R9 dc imm alt kept");
    step(4'd10, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R10 swap back");
    // R11 step and wrap
    step(4'd9, 0, 0, 16'h0, 8'h0, 16'h0, 16'hFFFE, "R9 dc imm");
    step(4'd11, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R11 step");
    step(4'd11, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R11 step wrap");
    // R12 sweep of every acc over three bases
    for (int b = 0; b < 3; b++) begin
      for (int a = 0; a < 256; a++) begin
        step(4'd9, 0, 0, 16'h0, 8'h0, 16'h0,
             (b == 0) ? 16'h0000 : (b == 1) ? 16'h7F80 : 16'hFFF0, "R9 base");
        step(4'd12, 0, 0, 16'h0, 8'(a), 16'h0, 16'h0, "R12 signed add");
      end
    end
    // R4 pc step and wrap
    step(4'd5, 0, 0, 16'h0, 8'h0, 16'h0, 16'hFFFF, "R7 jump");
    step(4'd1, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R4 pc wrap");
    step(4'd1, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R4 pc step");
    // R5 / R6 / R7 / R8
    step(4'd2, 0, 0, 16'h0, 8'h0, 16'h1357, 16'h0, "R5 pc pair");
    step(4'd3, 0, 0, 16'h0, 8'h0, 16'hC0DE, 16'h0, "R5 call pair");
    step(4'd6, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R6 return");
    step(4'd4, 0, 0, 16'h0, 8'h0, 16'h0, 16'h8421, "R7 call imm");
    step(4'd7, 0, 0, 16'h0, 8'h0, 16'h2468, 16'h0, "R8 ret load");
    step(4'd6, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R6 return loaded");
    // R3 interrupt with a competing op
    step(4'd5, 0, 1, 16'hF00D, 8'h0, 16'h0, 16'h1111, "R3 irq over jump");
    step(4'd11, 0, 1, 16'hABCD, 8'h0, 16'h0, 16'h0, "R3 irq holds dc");
    // R2 processor reset event
    step(4'd10, 1, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R2 vec reset holds dc");
    step(4'd1, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R4 pc step");
    step(4'd12, 1, 1, 16'h7777, 8'h80, 16'h0, 16'h0, "R2 vec reset beats irq");
    // R13 idle codes
    for (int c = 13; c < 16; c++)
      step(4'(c), 0, 0, 16'h0, 8'hFF, 16'hFFFF, 16'hFFFF, "R13 unused code");
    step(4'd0, 0, 0, 16'h0, 8'hFF, 16'hFFFF, 16'hFFFF, "R13 nop");
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = next_rand(lfsr);
      step(lfsr[3:0], (lfsr[9:4] == 6'd0), (lfsr[15:10] == 6'd1),
           lfsr[31:16], lfsr[23:16], lfsr[31:16], lfsr[19:4], "R13 mixed traffic");
    end
    // R1 mid-run clear
    do_clear("R1 mid-run clear");
    step(4'd0, 0, 0, 16'h0, 8'h0, 16'h0, 16'h0, "R13 idle after clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule